// File: doc/BRIEF.md
# Interrupt-capable general-purpose I/O bank

This block controls a group of general-purpose pins through a small word-addressed register interface. Each pin has its own set of configuration bits: direction, drive value, alternate-signal select, a value for sleep mode, a value for battery fault, and interrupt settings. The interrupt settings choose edge or level detection, the polarity, and a mask for normal mode and a mask for sleep mode. Incoming pin levels pass through a two-stage synchroniser. A per-pin detector turns them into events, and each event latches into a sticky status bit. Software clears a status bit by writing 1 to it. A single bank interrupt is raised while any latched bit is not masked by the mask that applies in the current mode.

A three-state mode machine selects where the drive values come from. The states are NORMAL, SLEEP and FAULT. The machine moves to FAULT whenever `batt_fault` is high. It moves to SLEEP when `sleep_req` is high and `batt_fault` is low. It moves to NORMAL when both are low. Every transition, NORMAL↔SLEEP, NORMAL↔FAULT and SLEEP↔FAULT, is taken on the clock edge after the inputs change. The pad tristate is not part of this block; it is driven from the exported direction bits. The alternate peripherals are also outside the block, and their values arrive on `alt_in`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, except the pin snapshot at 0x30, which shows the synchronised pins. The synchroniser resets to all ones. After reset `pad_out` is 0 and `irq` is 0.
- R2: The writable configuration registers read back what was last written. Their byte offsets are: interrupt mask 0x00, direction 0x04, drive value 0x08, trigger type 0x0C, edge polarity 0x10, level polarity 0x14, sleep mask 0x18, sleep drive value 0x1C, fault drive value 0x20, alternate select 0x28, sleep configuration 0x2C.
- R3: Offset 0x30 returns the pin levels two clocks after they are applied. Writes to offset 0x30 have no effect.
- R4: When trigger-type bit = 1 (edge mode), edge-polarity bit = 1 detects a rising edge and 0 detects a falling edge. The status bit at 0x24 reads 1 three clock edges after the pin changes, and it stays set until it is cleared.
- R5: When trigger-type bit = 0 (level mode), level-polarity bit = 1 detects a high level and 0 detects a low level.
- R6: Writing 1 to a status bit clears it. A clear takes priority over an event in the same cycle. A level that is still present sets the bit again on the next edge.
- R7: `irq` is high when a status bit is set whose mask bit is 0. The mask at 0x00 applies in NORMAL and FAULT. The mask at 0x18 applies in SLEEP.
- R8: A pin whose direction bit is 0 drives `pad_out` low. In NORMAL, an output pin drives its `alt_in` bit when its alternate-select bit is 1, and its drive-value bit otherwise.
- R9: In SLEEP, output pins drive the sleep drive value. In FAULT, they drive the fault drive value. FAULT wins when both requests are high. A mode change shows on `pad_out` one edge after the request inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| pad_in | input | 16 | Asynchronous pin levels |
| alt_in | input | 16 | Values from the alternate peripherals |
| sleep_req | input | 1 | Sleep mode request |
| batt_fault | input | 1 | Battery fault indication |
| pad_out | output | 16 | Value to drive on each pin |
| pad_oe | output | 16 | Direction bits (1 = output) |
| irq | output | 1 | Bank interrupt |

## Verification
Two cases are the hardest to reach from the ports. The first is a status clear and a persisting level event landing in the same cycle. The bench holds a level-high condition on one pin, writes the clear, and samples the status right after that edge and again one edge later. The second is the three-edge detection latency. The bench changes a pin on a falling clock edge and reads the status after the second and the third rising edge. Random register contents, `alt_in` values and mode requests cover the drive selection. A directed step into FAULT checks the one-edge mode delay.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_IMASK  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_DIR    = 6'h04;
    localparam logic [REG_AW-1:0] OFS_DRV    = 6'h08;
    localparam logic [REG_AW-1:0] OFS_TTYPE  = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_EPOL   = 6'h10;
    localparam logic [REG_AW-1:0] OFS_LPOL   = 6'h14;
    localparam logic [REG_AW-1:0] OFS_SMASK  = 6'h18;
    localparam logic [REG_AW-1:0] OFS_SDRV   = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_FDRV   = 6'h20;
    localparam logic [REG_AW-1:0] OFS_ISTAT  = 6'h24;
    localparam logic [REG_AW-1:0] OFS_ALTSEL = 6'h28;
    localparam logic [REG_AW-1:0] OFS_SCFG   = 6'h2C;
    localparam logic [REG_AW-1:0] OFS_PINS   = 6'h30;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_SLEEP  = 2'd1,
        MODE_FAULT  = 2'd2
    } mode_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            cur  <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            meta <= d;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] trig_edge,
    input  logic [W-1:0] edge_rise,
    input  logic [W-1:0] lvl_high,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_seen;
        logic fall_seen;
        assign rise_seen = cur[i] & ~prev[i];
        assign fall_seen = ~cur[i] & prev[i];
        always_comb begin
            if (trig_edge[i]) evt[i] = edge_rise[i] ? rise_seen : fall_seen;
            else              evt[i] = lvl_high[i] ? cur[i] : ~cur[i];
        end
    end
endmodule

// File: rtl/gpio_mode_fsm.sv
module gpio_mode_fsm
    import gpio_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sleep_req,
    input  logic  batt_fault,
    output mode_t mode
);
    mode_t state_q;
    mode_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: begin
                if (batt_fault)     state_d = MODE_FAULT;
                else if (sleep_req) state_d = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (batt_fault)      state_d = MODE_FAULT;
                else if (!sleep_req) state_d = MODE_NORMAL;
            end
            MODE_FAULT: begin
                if (!batt_fault)    state_d = sleep_req ? MODE_SLEEP : MODE_NORMAL;
            end
            default: state_d = MODE_NORMAL;
        endcase
    end

    assign mode = state_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] alt_in,
    input  logic                sleep_req,
    input  logic                batt_fault,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam logic [NUM_PINS-1:0] SYNC_IDLE = '1;

    logic [NUM_PINS-1:0] imask_q, dir_q, drv_q, ttype_q, epol_q, lpol_q;
    logic [NUM_PINS-1:0] smask_q, sdrv_q, fdrv_q, istat_q, altsel_q, scfg_q;
    logic [NUM_PINS-1:0] pin_cur, pin_prev, evt, clr_bits, eff_mask, sel_val;
    mode_t               mode;

    gpio_sync #(.W(NUM_PINS), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .cur(pin_cur), .prev(pin_prev)
    );

    gpio_event_detect #(.W(NUM_PINS)) u_detect (
        .cur(pin_cur), .prev(pin_prev), .trig_edge(ttype_q),
        .edge_rise(epol_q), .lvl_high(lpol_q), .evt(evt)
    );

    gpio_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .batt_fault(batt_fault), .mode(mode)
    );

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imask_q  <= '0; dir_q   <= '0; drv_q    <= '0; ttype_q <= '0;
            epol_q   <= '0; lpol_q  <= '0; smask_q  <= '0; sdrv_q  <= '0;
            fdrv_q   <= '0; altsel_q <= '0; scfg_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_IMASK:  imask_q  <= reg_wdata;
                OFS_DIR:    dir_q    <= reg_wdata;
                OFS_DRV:    drv_q    <= reg_wdata;
                OFS_TTYPE:  ttype_q  <= reg_wdata;
                OFS_EPOL:   epol_q   <= reg_wdata;
                OFS_LPOL:   lpol_q   <= reg_wdata;
                OFS_SMASK:  smask_q  <= reg_wdata;
                OFS_SDRV:   sdrv_q   <= reg_wdata;
                OFS_FDRV:   fdrv_q   <= reg_wdata;
                OFS_ALTSEL: altsel_q <= reg_wdata;
                OFS_SCFG:   scfg_q   <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Sticky status: a clear in the same cycle beats a new event
    assign clr_bits = (reg_wr && reg_addr == OFS_ISTAT) ? reg_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) istat_q <= '0;
        else        istat_q <= (istat_q | evt) & ~clr_bits;
    end

    always_comb begin
        case (reg_addr)
            OFS_IMASK:  reg_rdata = imask_q;
            OFS_DIR:    reg_rdata = dir_q;
            OFS_DRV:    reg_rdata = drv_q;
            OFS_TTYPE:  reg_rdata = ttype_q;
            OFS_EPOL:   reg_rdata = epol_q;
            OFS_LPOL:   reg_rdata = lpol_q;
            OFS_SMASK:  reg_rdata = smask_q;
            OFS_SDRV:   reg_rdata = sdrv_q;
            OFS_FDRV:   reg_rdata = fdrv_q;
            OFS_ISTAT:  reg_rdata = istat_q;
            OFS_ALTSEL: reg_rdata = altsel_q;
            OFS_SCFG:   reg_rdata = scfg_q;
            OFS_PINS:   reg_rdata = pin_cur;
            default:    reg_rdata = '0;
        endcase
    end

    // Output selection driven by the mode state
    always_comb begin
        unique case (mode)
            MODE_NORMAL: begin
                sel_val  = (altsel_q & alt_in) | (~altsel_q & drv_q);
                eff_mask = imask_q;
            end
            MODE_SLEEP: begin
                sel_val  = sdrv_q;
                eff_mask = smask_q;
            end
            MODE_FAULT: begin
                sel_val  = fdrv_q;
                eff_mask = imask_q;
            end
            default: begin
                sel_val  = '0;
                eff_mask = '1;
            end
        endcase
    end

    assign pad_out = sel_val & dir_q;
    assign pad_oe  = dir_q;
    assign irq     = |(istat_q & ~eff_mask);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [REG_AW-1:0]   reg_addr,
    input logic [NUM_PINS-1:0] reg_wdata,
    input logic                batt_fault,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] imask,
    input logic [NUM_PINS-1:0] istat,
    input mode_t               mode
);
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ISTAT) |=> ((istat & $past(reg_wdata)) == '0));

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == OFS_ISTAT) |=> (($past(istat) & ~istat) == '0));

    p_fault_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        batt_fault |=> (mode == MODE_FAULT));

    p_input_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SLEEP && imask == '1) |-> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .batt_fault(batt_fault), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq), .imask(imask_q), .istat(istat_q), .mode(mode)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] pad_in = 16'hFFFF;
    logic [15:0] alt_in = '0;
    logic        sleep_req = 1'b0;
    logic        batt_fault = 1'b0;
    logic [15:0] pad_out, pad_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .alt_in(alt_in), .sleep_req(sleep_req), .batt_fault(batt_fault),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        reg_addr = a; #0.5;
        d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] exp_pad(input logic [15:0] dir, drv, alt, ain,
                                            sdrv, fdrv, input logic slp, flt);
        logic [15:0] v;
        if (flt)      v = fdrv;
        else if (slp) v = sdrv;
        else          v = (alt & ain) | (~alt & drv);
        return v & dir;
    endfunction

    initial begin
        logic [15:0] r;
        logic [5:0] cfg_ofs [11] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14,
                                     6'h18, 6'h1C, 6'h20, 6'h28, 6'h2C};
        void'($urandom(32'd2024));
        cycles(3);
        @(negedge clk); rst_n = 1'b1;
        #1;

        // R1: reset state
        for (int k = 0; k < 11; k++) begin
            rd(cfg_ofs[k], r); check("R1 cfg reg zero", r, 16'h0000);
        end
        rd(6'h24, r); check("R1 status zero", r, 16'h0000);
        rd(6'h30, r); check("R1 pin snapshot", r, 16'hFFFF);
        check("R1 pad_out", pad_out, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);

        // R2: random readback of configuration registers
        for (int k = 0; k < 11; k++) begin
            logic [15:0] v;
            v = 16'($urandom);
            wr(cfg_ofs[k], v);
            rd(cfg_ofs[k], r); check("R2 readback", r, v);
        end
        wr(6'h00, 16'hFFFF); wr(6'h0C, 16'hFFFF); wr(6'h10, 16'h0000);
        wr(6'h14, 16'h0000); wr(6'h18, 16'hFFFF); wr(6'h24, 16'hFFFF);
        rd(6'h24, r); check("R6 clear all", r, 16'h0000);

        // R3: pin snapshot and ignored write
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = 16'($urandom);
            @(negedge clk); pad_in = v;
            cycles(2);
            rd(6'h30, r); check("R3 snapshot after two edges", r, v);
            wr(6'h30, ~v);
            rd(6'h30, r); check("R3 write ignored", r, v);
        end
        @(negedge clk); pad_in = 16'hFFFF;
        cycles(4);
        wr(6'h24, 16'hFFFF);

        // R4: edge detection with exact latency
        wr(6'h10, 16'h0001);
        @(negedge clk); pad_in = 16'hFFFC;
        cycles(2);
        rd(6'h24, r); check("R4 not yet after two edges", r, 16'h0000);
        cycles(1);
        rd(6'h24, r); check("R4 falling on pin1 only", r, 16'h0002);
        @(negedge clk); pad_in = 16'hFFFF;
        cycles(4);
        rd(6'h24, r); check("R4 rising on pin0, sticky pin1", r, 16'h0003);
        wr(6'h24, 16'hFFFF);
        rd(6'h24, r); check("R6 clear edge bits", r, 16'h0000);

        // R5: level detection
        wr(6'h14, 16'h0010);
        wr(6'h0C, 16'hFFEF);
        cycles(1);
        rd(6'h24, r); check("R5 level high on pin4", r, 16'h0010);
        @(negedge clk); pad_in = 16'hFFDF;
        wr(6'h0C, 16'hFFCF);
        cycles(4);
        rd(6'h24, r); check("R5 level low on pin5", r, 16'h0030);
        check("R7 all masked", {15'd0, irq}, 16'h0000);
        wr(6'h00, 16'hFFEF);
        check("R7 unmasked pin4", {15'd0, irq}, 16'h0001);

        // R6: clear beats same-cycle level, then re-set
        wr(6'h24, 16'h0010);
        rd(6'h24, r); check("R6 clear wins", r, 16'h0020);
        cycles(1);
        rd(6'h24, r); check("R6 level re-sets", r, 16'h0030);
        @(negedge clk); pad_in = 16'hFFFF;
        wr(6'h0C, 16'hFFFF);
        cycles(4);
        wr(6'h24, 16'hFFFF);
        rd(6'h24, r); check("R6 cleared after edge mode", r, 16'h0000);
        check("R7 irq low when clear", {15'd0, irq}, 16'h0000);

        // R7: sleep mask used in sleep mode
        @(negedge clk); pad_in = 16'hFFFB;
        cycles(4);
        wr(6'h00, 16'hFFFB);
        check("R7 normal unmasked", {15'd0, irq}, 16'h0001);
        wr(6'h18, 16'h0004);
        @(negedge clk); sleep_req = 1'b1;
        cycles(2);
        check("R7 sleep mask hides", {15'd0, irq}, 16'h0000);
        wr(6'h18, 16'h0000);
        check("R7 sleep mask open", {15'd0, irq}, 16'h0001);
        @(negedge clk); sleep_req = 1'b0;
        wr(6'h00, 16'hFFFF);
        check("R7 back to normal mask", {15'd0, irq}, 16'h0000);
        @(negedge clk); pad_in = 16'hFFFF;
        cycles(4);
        wr(6'h24, 16'hFFFF);

        // R9: one-edge delay into FAULT
        wr(6'h04, 16'hFFFF); wr(6'h08, 16'h00FF); wr(6'h28, 16'h0000);
        wr(6'h20, 16'hF0F0); wr(6'h1C, 16'h3C3C);
        @(negedge clk); batt_fault = 1'b1; sleep_req = 1'b1;
        #0.5;
        check("R9 before edge still normal", pad_out, 16'h00FF);
        cycles(1);
        check("R9 fault wins over sleep", pad_out, 16'hF0F0);
        @(negedge clk); batt_fault = 1'b0;
        cycles(1);
        check("R9 sleep value", pad_out, 16'h3C3C);
        @(negedge clk); sleep_req = 1'b0;
        cycles(1);

        // R8/R9: random drive selection
        for (int k = 0; k < 40; k++) begin
            logic [15:0] dv, ov, av, ai, sv, fv;
            logic s, f;
            dv = 16'($urandom); ov = 16'($urandom); av = 16'($urandom);
            ai = 16'($urandom); sv = 16'($urandom); fv = 16'($urandom);
            s = ($urandom % 3) == 0; f = ($urandom % 4) == 0;
            wr(6'h04, dv); wr(6'h08, ov); wr(6'h28, av);
            wr(6'h1C, sv); wr(6'h20, fv);
            @(negedge clk); alt_in = ai; sleep_req = s; batt_fault = f;
            cycles(1);
            check(f ? "R9 random fault" : (s ? "R9 random sleep" : "R8 random normal"),
                  pad_out, exp_pad(dv, ov, av, ai, sv, fv, s, f));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule